// File: doc/BRIEF.md
# Register-programmed UART with FIFOs

This block is an asynchronous serial transmitter and receiver that software drives through a small word-addressed register bus. The bus covers eight 32-bit words, so the window is 32 bytes, and only the low byte of each word is used. Software pushes characters into a transmit queue and pops received characters from a receive queue. Each received character carries its own error bits. A separate status word shows those bits for the character that was popped most recently.

The bit rate comes from a 12-bit divisor that is split across two registers. Each serial bit lasts 16 ticks of an oversampling clock, and that tick runs at the system clock divided by (divisor + 1). A frame-format byte selects word length, parity, stop bits, queue depth and line break. New divisor and format values are staged and take effect only when software writes the enable bit as 1. The only exception is the break bit, which acts at once. Two interrupt lines are provided: one asserts while received data is waiting, and the other asserts while the transmit queue has space.

Word map: 0 data, 1 receive status, 2 divisor bits 7:0, 3 divisor bits 11:8 (in bits 3:0), 4 frame format, 5 enable, 6 flags. The bus and the serial logic run on one clock.

Top module: `uart_core`

## Requirements
- R1: After reset, `txd` is high, both interrupts are low and the flag word (word 6) reads 0x10, which means receive queue empty, transmit queue not full and transmitter not busy.
- R2: A transmitted frame is one low start bit, then the data bits with the least significant bit first, then a high stop bit. Each bit lasts 16*(divisor+1) clock cycles.
- R3: In frame byte word 4, bits 6:5 set the word length (00=5, 01=6, 10=7, 11=8 bits). Bit 1 enables parity. Bit 2 selects even parity when set and odd parity when clear. Bit 3 selects two stop bits.
- R4: A write to word 5 with bit 0 clear halts both serial engines. Staged divisor and format values are applied only by a write to word 5 with bit 0 set. A format write without that step leaves the line format unchanged.
- R5: While bit 0 of word 4 is set, `txd` is held low within two cycles. When the bit is cleared, the line returns high.
- R6: With bit 4 of word 4 set, the transmit queue holds 16 characters. Writes beyond that are dropped, and flag bit 5 reads 1 while the queue is full.
- R7: With bit 4 of word 4 clear, each queue holds one character. A second write while one character is waiting is dropped.
- R8: A received character sets `rx_irq` and clears flag bit 4. Reading word 0 returns the character and pops it, and word 1 then reads 0 for an error-free character.
- R9: After a pop, word 1 bit 0 shows a framing error (first stop bit sampled low) and bit 1 shows a parity mismatch.
- R10: A low pulse on `rxd` that is shorter than half a bit time is rejected and stores nothing.
- R11: If a complete character arrives while the receive queue is full, that character is discarded, and the next character that is stored has bit 2 set in word 1.
- R12: Flag bit 3 reads 1 while a character is queued or being shifted out, and reads 0 once the line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index within the 32-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rx_irq | output | 1 | Receive data waiting |
| tx_irq | output | 1 | Transmit queue has room while enabled |

## Verification
The embedded assertions check, on every cycle, the queue bookkeeping. They confirm that a write into a full transmit queue leaves its count unchanged, that a pop of an empty receive queue does nothing, and that a character arriving at a full receive queue raises the pending overrun. They also check that clearing the enable stops both engines and that every frame starts with a low line. Only the directed scenarios can show that the frame itself is correct. That covers bit order, bit period under a given divisor, parity polarity, two stop bits, the staging of format changes, rejection of a start glitch, and which stored character ends up carrying the overrun mark.

// File: rtl/uart_core.sv
module uart_core #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int DIVW = 12;
  localparam logic [2:0] W_DATA = 3'd0, W_STAT = 3'd1, W_DLO = 3'd2, W_DMID = 3'd3,
                         W_FMT = 3'd4, W_EN = 3'd5, W_FLAG = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} ser_t;

  logic [7:0] div_lo;
  logic [3:0] div_mid;
  logic [6:0] fmt;
  logic       en;
  logic [DIVW-1:0] div_a;
  logic [6:1] fmt_a;

  wire wr_any  = bus_sel & bus_wr;
  wire rd_data = bus_sel & ~bus_wr & (bus_addr == W_DATA);
  wire wr_data = wr_any & (bus_addr == W_DATA);
  wire go      = wr_any & (bus_addr == W_EN) & bus_wdata[0];

  wire       par_en   = fmt_a[1];
  wire       par_even = fmt_a[2];
  wire       two_stop = fmt_a[3];
  wire       fifo_on  = fmt_a[4];
  wire [1:0] wlen     = fmt_a[6:5];
  wire [2:0] last_idx = {1'b0, wlen} + 3'd4;
  wire [CW-1:0] cap   = fifo_on ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_lo <= '0; div_mid <= '0; fmt <= 7'h70; en <= 1'b0;
      div_a <= '0; fmt_a <= 6'h38;
    end else if (wr_any) begin
      case (bus_addr)
        W_DLO:  div_lo  <= bus_wdata;
        W_DMID: div_mid <= bus_wdata[3:0];
        W_FMT:  fmt     <= bus_wdata[6:0];
        W_EN: begin
          en <= bus_wdata[0];
          if (bus_wdata[0]) begin
            div_a <= {div_mid, div_lo};
            fmt_a <= fmt[6:1];
          end
        end
        default: ;
      endcase
    end

  logic [DIVW-1:0] bcnt;
  wire tick = en & (bcnt == div_a);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else bcnt <= (!en || tick) ? '0 : bcnt + 1'b1;

  // transmit queue and shifter
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  ser_t          tx_st;
  logic [7:0]    tx_sh;
  logic [2:0]    tx_idx;
  logic [3:0]    tx_tk;
  logic          tx_par, tx_stop2;

  wire tx_push = wr_data & (tx_cnt < cap);
  wire tx_load = tick & (tx_st == S_IDLE) & (tx_cnt != 0);
  wire [7:0] tx_mask = 8'hFF >> (2'd3 - wlen);
  wire [7:0] tx_head = tx_mem[tx_rp] & tx_mask;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_load) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_load);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st <= S_IDLE; tx_sh <= '0; tx_idx <= '0; tx_tk <= '0;
      tx_par <= 1'b0; tx_stop2 <= 1'b0;
    end else if (!en) begin
      tx_st <= S_IDLE;
    end else if (tx_load) begin
      tx_st  <= S_START;
      tx_sh  <= tx_head;
      tx_par <= par_even ? ^tx_head : ~^tx_head;
      tx_tk  <= '0;
    end else if (tick && tx_st != S_IDLE) begin
      tx_tk <= tx_tk + 1'b1;
      if (tx_tk == 4'd15) begin
        case (tx_st)
          S_START: begin tx_st <= S_DATA; tx_idx <= '0; end
          S_DATA: begin
            tx_sh <= tx_sh >> 1;
            if (tx_idx == last_idx) begin
              tx_st <= par_en ? S_PAR : S_STOP;
              tx_stop2 <= 1'b0;
            end else tx_idx <= tx_idx + 1'b1;
          end
          S_PAR: begin tx_st <= S_STOP; tx_stop2 <= 1'b0; end
          S_STOP:
            if (two_stop && !tx_stop2) tx_stop2 <= 1'b1;
            else tx_st <= S_IDLE;
          default: tx_st <= S_IDLE;
        endcase
      end
    end

  logic line;
  always_comb
    case (tx_st)
      S_START: line = 1'b0;
      S_DATA:  line = tx_sh[0];
      S_PAR:   line = tx_par;
      default: line = 1'b1;
    endcase
  assign txd = line & ~fmt[0];

  // receive shifter and queue
  logic          rs1, rs2;
  ser_t          rx_st;
  logic [7:0]    rx_sh;
  logic [2:0]    rx_idx;
  logic [3:0]    rx_tk;
  logic          rx_acc, rx_perr, ovr_pend;
  logic [10:0]   rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    stat;

  wire rx_pop  = rd_data & (rx_cnt != 0);
  wire rx_fin  = (rx_st == S_STOP) & tick & (rx_tk == 4'd15);
  wire rx_room = (rx_cnt < cap) | rx_pop;
  wire rx_push = rx_fin & rx_room;
  wire [10:0] rx_word = {ovr_pend, rx_perr, ~rs2, rx_sh >> (2'd3 - wlen)};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rs1 <= 1'b1; rs2 <= 1'b1; end
    else begin rs1 <= rxd; rs2 <= rs1; end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= S_IDLE; rx_sh <= '0; rx_idx <= '0; rx_tk <= '0;
      rx_acc <= 1'b0; rx_perr <= 1'b0;
    end else if (!en) begin
      rx_st <= S_IDLE;
    end else if (tick) begin
      rx_tk <= rx_tk + 1'b1;
      case (rx_st)
        S_IDLE:
          if (!rs2) begin rx_st <= S_START; rx_tk <= '0; end
        S_START:
          if (rx_tk == 4'd7) begin
            rx_tk <= '0;
            if (rs2) rx_st <= S_IDLE;
            else begin
              rx_st <= S_DATA; rx_idx <= '0; rx_acc <= 1'b0; rx_perr <= 1'b0;
            end
          end
        S_DATA:
          if (rx_tk == 4'd15) begin
            rx_tk  <= '0;
            rx_sh  <= {rs2, rx_sh[7:1]};
            rx_acc <= rx_acc ^ rs2;
            if (rx_idx == last_idx) rx_st <= par_en ? S_PAR : S_STOP;
            else rx_idx <= rx_idx + 1'b1;
          end
        S_PAR:
          if (rx_tk == 4'd15) begin
            rx_tk <= '0;
            rx_perr <= rx_acc ^ rs2 ^ ~par_even;
            rx_st <= S_STOP;
          end
        S_STOP:
          if (rx_tk == 4'd15) rx_st <= S_IDLE;
        default: rx_st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; ovr_pend <= 1'b0; stat <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop) begin
        rx_rp <= rx_rp + 1'b1;
        stat  <= rx_mem[rx_rp][10:8];
      end
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (rx_fin) ovr_pend <= ~rx_room;
    end

  wire busy    = (tx_st != S_IDLE) | (tx_cnt != 0);
  wire tx_full = (tx_cnt >= cap);

  always_comb
    case (bus_addr)
      W_DATA:  bus_rdata = rx_mem[rx_rp][7:0];
      W_STAT:  bus_rdata = {5'b0, stat};
      W_DLO:   bus_rdata = div_lo;
      W_DMID:  bus_rdata = {4'b0, div_mid};
      W_FMT:   bus_rdata = {1'b0, fmt};
      W_EN:    bus_rdata = {7'b0, en};
      W_FLAG:  bus_rdata = {2'b0, tx_full, rx_cnt == 0, busy, 3'b0};
      default: bus_rdata = 8'h00;
    endcase

  assign rx_irq = (rx_cnt != 0);
  assign tx_irq = en & ~tx_full;

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_cnt >= cap && !tx_load) |=> tx_cnt == $past(tx_cnt));
  p_tx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_cnt == 0 && !rx_fin) |=> rx_cnt == 0);
  p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_st == S_IDLE && rx_st == S_IDLE));
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !txd);
  p_overrun_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fin && !rx_room) |=> (ovr_pend && rx_cnt == $past(rx_cnt)));
endmodule

// File: tb/tb_uart_core.sv
module tb_uart_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rxd = 1'b1, txd, rx_irq, tx_irq;
  int checks = 0, fails = 0;

  uart_core dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .rx_irq(rx_irq), .tx_irq(tx_irq));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic cfg(input logic [11:0] dv, input logic [7:0] f);
    wr(3'd5, 8'h00); wr(3'd2, dv[7:0]); wr(3'd3, {4'h0, dv[11:8]});
    wr(3'd4, f); wr(3'd5, 8'h01);
  endtask

  // captures one frame from txd; nb data bits, np parity bits, ns stop bits
  task automatic grab(input int nb, input int np, input int ns, input int bc,
                      output logic [7:0] d, output logic p, output logic [1:0] st, output bit ok);
    int w = 0;
    d = '0; p = 1'b0; st = '0; ok = 1'b1;
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    if (w >= 4000) begin ok = 1'b0; return; end
    repeat (bc / 2) @(negedge clk);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < nb; i++) begin repeat (bc) @(negedge clk); d[i] = txd; end
    if (np != 0) begin repeat (bc) @(negedge clk); p = txd; end
    for (int i = 0; i < ns; i++) begin repeat (bc) @(negedge clk); st[i] = txd; end
  endtask

  // pm: 0 none, 1 even, 2 odd, 3 even with the bit inverted
  task automatic send(input logic [7:0] d, input int nb, input int pm, input logic sv, input int bc);
    logic pb;
    pb = ^(d & (8'hFF >> (8 - nb)));
    if (pm == 2) pb = ~pb;
    if (pm == 3) pb = ~pb;
    @(negedge clk); rxd = 1'b0; repeat (bc) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (bc) @(negedge clk); end
    if (pm != 0) begin rxd = pb; repeat (bc) @(negedge clk); end
    rxd = sv; repeat (bc) @(negedge clk);
    rxd = 1'b1; repeat (bc) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] f;
    chk(txd === 1'b1, "R1 txd idle", txd, 1);
    chk(rx_irq === 1'b0 && tx_irq === 1'b0, "R1 irqs", {rx_irq, tx_irq}, 0);
    rd(3'd6, f);
    chk(f === 8'h10, "R1 flags", f, 8'h10);
  endtask

  task automatic t_tx_8n1;
    logic [7:0] d; logic p; logic [1:0] s; bit ok;
    cfg(12'd1, 8'h70);
    wr(3'd0, 8'hA5);
    grab(8, 0, 1, 32, d, p, s, ok);
    chk(ok && d === 8'hA5, "R2 data with divisor 1", d, 8'hA5);
    chk(s[0] === 1'b1, "R2 stop high", s, 1);
  endtask

  task automatic t_tx_formats;
    logic [7:0] d; logic p; logic [1:0] s; bit ok;
    cfg(12'd0, 8'h5E);
    wr(3'd0, 8'h37);
    grab(7, 1, 2, 16, d, p, s, ok);
    chk(ok && d === 8'h37, "R3 7-bit data", d, 8'h37);
    chk(p === ^(8'h37 & 8'h7F), "R3 even parity", p, ^(8'h37 & 8'h7F));
    chk(s === 2'b11, "R3 two stop bits", s, 3);
    cfg(12'd0, 8'h12);
    wr(3'd0, 8'hFF);
    grab(5, 1, 1, 16, d, p, s, ok);
    chk(ok && d === 8'h1F, "R3 5-bit data", d, 8'h1F);
    chk(p === ~^(8'h1F), "R3 odd parity", p, ~^(8'h1F));
  endtask

  task automatic t_enable;
    logic [7:0] d; logic p; logic [1:0] s; bit ok; bit stayed;
    cfg(12'd0, 8'h70);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h55);
    stayed = 1'b1;
    repeat (200) begin @(negedge clk); if (txd !== 1'b1) stayed = 1'b0; end
    chk(stayed, "R4 disabled stays idle", stayed, 1);
    wr(3'd5, 8'h01);
    grab(8, 0, 1, 16, d, p, s, ok);
    chk(ok && d === 8'h55, "R4 sends after enable", d, 8'h55);
    wr(3'd4, 8'h7E);
    wr(3'd0, 8'h0F);
    grab(8, 0, 1, 16, d, p, s, ok);
    chk(ok && d === 8'h0F && s[0] === 1'b1, "R4 staged format not applied", {d, s[0]}, {8'h0F, 1'b1});
  endtask

  task automatic t_break;
    cfg(12'd0, 8'h70);
    wr(3'd4, 8'h71);
    repeat (2) @(negedge clk);
    chk(txd === 1'b0, "R5 break low", txd, 0);
    wr(3'd4, 8'h70);
    repeat (2) @(negedge clk);
    chk(txd === 1'b1, "R5 break released", txd, 1);
  endtask

  task automatic t_fifo;
    logic [7:0] f, d; logic p; logic [1:0] s; bit ok; bit good; bit stayed;
    cfg(12'd0, 8'h70);
    wr(3'd5, 8'h00);
    for (int i = 0; i < 17; i++) wr(3'd0, 8'(i + 8'h20));
    rd(3'd6, f);
    chk(f[5] === 1'b1, "R6 full flag", f, 8'h20);
    wr(3'd5, 8'h01);
    rd(3'd6, f);
    chk(f[3] === 1'b1, "R12 busy while sending", f, 8'h08);
    good = 1'b1;
    for (int i = 0; i < 16; i++) begin
      grab(8, 0, 1, 16, d, p, s, ok);
      if (!ok || d !== 8'(i + 8'h20)) good = 1'b0;
    end
    chk(good, "R6 sixteen in order", good, 1);
    stayed = 1'b1;
    repeat (300) begin @(negedge clk); if (txd !== 1'b1) stayed = 1'b0; end
    chk(stayed, "R6 seventeenth dropped", stayed, 1);
    rd(3'd6, f);
    chk(f[3] === 1'b0, "R12 idle not busy", f, 0);
  endtask

  task automatic t_nofifo;
    logic [7:0] f, d; logic p; logic [1:0] s; bit ok; bit stayed;
    cfg(12'd0, 8'h60);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h11);
    rd(3'd6, f);
    chk(f[5] === 1'b1, "R7 full after one", f, 8'h20);
    wr(3'd0, 8'h22);
    wr(3'd5, 8'h01);
    grab(8, 0, 1, 16, d, p, s, ok);
    chk(ok && d === 8'h11, "R7 held char", d, 8'h11);
    stayed = 1'b1;
    repeat (300) begin @(negedge clk); if (txd !== 1'b1) stayed = 1'b0; end
    chk(stayed, "R7 second write dropped", stayed, 1);
  endtask

  task automatic t_rx_basic;
    logic [7:0] f, d, st;
    cfg(12'd0, 8'h70);
    send(8'hC3, 8, 0, 1'b1, 16);
    chk(rx_irq === 1'b1, "R8 rx irq", rx_irq, 1);
    rd(3'd6, f);
    chk(f[4] === 1'b0, "R8 not empty", f, 0);
    rd(3'd0, d);
    chk(d === 8'hC3, "R8 data", d, 8'hC3);
    rd(3'd1, st);
    chk(st === 8'h00, "R8 clean status", st, 0);
    rd(3'd6, f);
    chk(f[4] === 1'b1, "R8 empty after pop", f, 8'h10);
  endtask

  task automatic t_rx_err;
    logic [7:0] d, st;
    cfg(12'd0, 8'h76);
    send(8'h81, 8, 3, 1'b1, 16);
    rd(3'd0, d); rd(3'd1, st);
    chk(d === 8'h81 && st === 8'h02, "R9 parity error", {d, st}, {8'h81, 8'h02});
    cfg(12'd0, 8'h70);
    send(8'h5A, 8, 0, 1'b0, 16);
    rd(3'd0, d); rd(3'd1, st);
    chk(d === 8'h5A && st === 8'h01, "R9 framing error", {d, st}, {8'h5A, 8'h01});
  endtask

  task automatic t_glitch;
    logic [7:0] f, d;
    cfg(12'd0, 8'h70);
    @(negedge clk); rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (300) @(negedge clk);
    rd(3'd6, f);
    chk(f[4] === 1'b1 && rx_irq === 1'b0, "R10 glitch rejected", f, 8'h10);
    send(8'h3C, 8, 0, 1'b1, 16);
    rd(3'd0, d);
    chk(d === 8'h3C, "R10 frame after glitch", d, 8'h3C);
  endtask

  task automatic t_overrun;
    logic [7:0] d, st; bit good;
    cfg(12'd0, 8'h70);
    for (int i = 0; i < 17; i++) send(8'(8'h40 + i), 8, 0, 1'b1, 16);
    good = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, d); rd(3'd1, st);
      if (d !== 8'(8'h40 + i) || st !== 8'h00) good = 1'b0;
    end
    chk(good, "R11 first sixteen kept", good, 1);
    send(8'h99, 8, 0, 1'b1, 16);
    rd(3'd0, d); rd(3'd1, st);
    chk(d === 8'h99 && st === 8'h04, "R11 overrun marked", {d, st}, {8'h99, 8'h04});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_tx_8n1;
    t_tx_formats;
    t_enable;
    t_break;
    t_fifo;
    t_nofifo;
    t_rx_basic;
    t_rx_err;
    t_glitch;
    t_overrun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule